// File: doc/BRIEF.md
# Asynchronous Burst ROM Read Sequencer

This block serves a single 16-byte line read from a bus master by running burst read cycles against an external asynchronous burst ROM. The ROM data bus is either 8 or 16 bits wide. The sequencer drives the ROM address, a chip select and a read strobe, samples the returned bytes after a fixed number of wait ticks and packs them into a 128-bit result. A done pulse marks the moment the line is complete.

A small configuration word chooses the bus width, whether the line is fetched as one long burst or as four short bursts, and a hold count. The hold count sets how long address and select stay valid after the strobe is released. The sequencer runs on a clock at twice the bus rate, so one tick is half a bus cycle and half-cycle hold delays come out exact. The configuration is captured when a request is accepted and stays fixed for that transfer.

Top module: `brom_burst_seq`

## Requirements
- R1: After reset, busy, done, rom_sel and rom_rd are low and cfg_rdata reads 0 (8-bit bus, splitting off, hold code 00).
- R2: In the configuration word, bit 0 selects a 16-bit bus (1) or an 8-bit bus (0), bit 3 turns burst splitting on, and bits 9:8 hold the hold code. Every other bit reads back 0 whatever was written.
- R3: A request seen while idle is accepted on that clock edge. busy, rom_sel and rom_rd rise together, and rom_addr takes req_addr with its low 4 bits cleared.
- R4: With splitting off, the line is fetched in one burst: 8 transfers on a 16-bit bus, 16 transfers on an 8-bit bus.
- R5: With splitting on, the line is fetched in four bursts, each starting at the next 4-byte offset: 2 transfers each on a 16-bit bus, 4 transfers each on an 8-bit bus.
- R6: Within a burst, rom_rd stays high and rom_addr advances by the bus width in bytes (1 or 2) after each sample. rom_rd is never high while rom_sel is low.
- R7: rom_rd falls on the edge that takes a burst's last sample. rom_sel falls, and rom_addr returns to 0, exactly 2*code+1 ticks later: that is 1, 3, 5 or 7 ticks, or 0.5, 1.5, 2.5 or 3.5 bus cycles.
- R8: Between the bursts of a split line, rom_sel stays low for exactly one tick. It then rises together with rom_rd at the next burst's address.
- R9: The first sample of each burst is taken FIRST_WAIT+1 ticks after its address appears. Each later sample is taken NEXT_WAIT+1 ticks after the address step before it. busy is therefore high for bursts*((FIRST_WAIT+1)+(beats-1)*(NEXT_WAIT+1)+hold_ticks)+(bursts-1) ticks.
- R10: Bytes are packed little-endian, with the byte at the lowest address in rd_data[7:0]. On a 16-bit bus, rom_din[7:0] is the byte at the even address and rom_din[15:8] the byte at the odd address. On an 8-bit bus, rom_din[15:8] is ignored.
- R11: done is high for exactly one tick, on the edge that takes the final sample, and rd_data holds the whole line while done is high. busy stays high until the final hold delay has ended.
- R12: Requests that arrive while busy is high are ignored. They change neither the running transfer nor what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| req_valid | input | 1 | Line read request |
| req_addr | input | ADDR_W | Request byte address (low 4 bits ignored) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-tick pulse when the line is complete |
| rd_data | output | 128 | Assembled line, lowest address in bits 7:0 |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_sel | output | 1 | ROM chip select, active high |
| rom_rd | output | 1 | ROM read strobe, active high |
| rom_din | input | 16 | ROM read data |

## Verification
The bench's ROM model returns a garbage word until an address has been stable for exactly the required number of wait ticks. A design that samples too early therefore packs garbage, while one that waits too long stretches the busy time past the computed total. Every hold window is timed in ticks for each hold code. This exposes an off-by-one, or a hold counted in bus cycles instead of half cycles, as a wrong window length. All four width and split combinations are run, and the number of select assertions is compared with the expected burst count, so a mode mix-up shows as a wrong burst count or wrong bytes. A request injected mid-transfer, and config bits written as ones, must leave the result and the readback untouched.

// File: rtl/brom_pkg.sv
package brom_pkg;
  localparam int CFG_W       = 32;
  localparam int FLD_WIDE    = 0;
  localparam int FLD_SPLIT   = 3;
  localparam int FLD_HOLD_LO = 8;
  localparam logic [CFG_W-1:0] CFG_MASK = 32'h0000_0309;
  localparam int LINE_BYTES  = 16;
  localparam int LINE_W      = LINE_BYTES * 8;
  localparam int IDX_W       = $clog2(LINE_BYTES);
  localparam int ROM_W       = 16;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ACCESS,
    S_HOLD,
    S_RESTART
  } seq_state_t;

  typedef struct packed {
    logic       wide;
    logic       split;
    logic [1:0] hold;
  } brom_cfg_t;
endpackage

// File: rtl/brom_cfg_reg.sv
module brom_cfg_reg
  import brom_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output brom_cfg_t        cfg
);
  brom_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.wide  <= wdata[FLD_WIDE];
      cfg_q.split <= wdata[FLD_SPLIT];
      cfg_q.hold  <= wdata[FLD_HOLD_LO +: 2];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[FLD_WIDE]         = cfg_q.wide;
    rdata[FLD_SPLIT]        = cfg_q.split;
    rdata[FLD_HOLD_LO +: 2] = cfg_q.hold;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/brom_shape.sv
module brom_shape
  import brom_pkg::*;
(
  input  brom_cfg_t        cfg,
  output logic [IDX_W-1:0] beat_mask,
  output logic [IDX_W-1:0] last_idx,
  output logic [2:0]       hold_ticks
);
  always_comb begin
    unique case ({cfg.split, cfg.wide})
      2'b00:   beat_mask = IDX_W'(15);
      2'b01:   beat_mask = IDX_W'(7);
      2'b10:   beat_mask = IDX_W'(3);
      default: beat_mask = IDX_W'(1);
    endcase
    last_idx   = cfg.wide ? IDX_W'(7) : IDX_W'(15);
    hold_ticks = {cfg.hold, 1'b1};
  end
endmodule

// File: rtl/brom_collect.sv
module brom_collect
  import brom_pkg::*;
#(
  parameter int NBYTES = LINE_BYTES,
  localparam int IW    = $clog2(NBYTES)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              wide,
  input  logic [IW-1:0]     idx,
  input  logic [ROM_W-1:0]  din,
  output logic [NBYTES*8-1:0] data
);
  logic [NBYTES*8-1:0] data_q;

  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    localparam logic [IW-1:0] NARROW_IDX = IW'(j);
    localparam logic [IW-1:0] WIDE_IDX   = IW'(j / 2);
    localparam bit            UPPER      = (j % 2) == 1;
    logic hit;
    assign hit = wide ? (idx == WIDE_IDX) : (idx == NARROW_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[j*8 +: 8] <= '0;
      end else if (cap && hit) begin
        data_q[j*8 +: 8] <= (wide && UPPER) ? din[15:8] : din[7:0];
      end
    end
  end

  assign data = data_q;
endmodule

// File: rtl/brom_burst_seq.sv
module brom_burst_seq
  import brom_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int FIRST_WAIT = 3,
  parameter int NEXT_WAIT  = 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [LINE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_sel,
  output logic              rom_rd,
  input  logic [ROM_W-1:0]  rom_din
);
  localparam int CNT_W = $clog2(FIRST_WAIT + NEXT_WAIT + 8) + 1;

  brom_cfg_t         cfg_now;
  brom_cfg_t         run_cfg_q;
  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic              busy_q, done_q, sel_q, rd_q, fin_q;
  logic              wide_q;
  logic [IDX_W-1:0]  beat_mask, last_idx;
  logic [2:0]        hold_ticks;
  logic              cap;
  logic [IDX_W-1:0]  idx_next;

  brom_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg_now)
  );

  brom_shape u_shape (
    .cfg        (run_cfg_q),
    .beat_mask  (beat_mask),
    .last_idx   (last_idx),
    .hold_ticks (hold_ticks)
  );

  assign wide_q   = run_cfg_q.wide;
  assign cap      = (state_q == S_ACCESS) && (cnt_q == '0);
  assign idx_next = idx_q + IDX_W'(1);

  brom_collect #(.NBYTES(LINE_BYTES)) u_collect (
    .clk  (clk),
    .rst  (rst),
    .cap  (cap),
    .wide (wide_q),
    .idx  (idx_q),
    .din  (rom_din),
    .data (rd_data)
  );

  function automatic logic [ADDR_W-1:0] beat_addr(
    input logic [ADDR_W-1:0] base,
    input logic [IDX_W-1:0]  i,
    input logic              w
  );
    return base + (ADDR_W'(i) << w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      run_cfg_q <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      base_q    <= '0;
      addr_q    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sel_q     <= 1'b0;
      rd_q      <= 1'b0;
      fin_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            run_cfg_q <= cfg_now;
            base_q    <= {req_addr[ADDR_W-1:4], 4'b0000};
            addr_q    <= {req_addr[ADDR_W-1:4], 4'b0000};
            busy_q    <= 1'b1;
            sel_q     <= 1'b1;
            rd_q      <= 1'b1;
            idx_q     <= '0;
            fin_q     <= 1'b0;
            cnt_q     <= CNT_W'(FIRST_WAIT);
            state_q   <= S_ACCESS;
          end
        end
        S_ACCESS: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            idx_q <= idx_next;
            if ((idx_q & beat_mask) == beat_mask) begin
              rd_q    <= 1'b0;
              cnt_q   <= CNT_W'(hold_ticks - 3'd1);
              state_q <= S_HOLD;
              if (idx_q == last_idx) begin
                done_q <= 1'b1;
                fin_q  <= 1'b1;
              end
            end else begin
              addr_q <= beat_addr(base_q, idx_next, wide_q);
              cnt_q  <= CNT_W'(NEXT_WAIT);
            end
          end
        end
        S_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            sel_q  <= 1'b0;
            addr_q <= '0;
            if (fin_q) begin
              busy_q  <= 1'b0;
              fin_q   <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_RESTART;
            end
          end
        end
        S_RESTART: begin
          sel_q   <= 1'b1;
          rd_q    <= 1'b1;
          addr_q  <= beat_addr(base_q, idx_q, wide_q);
          cnt_q   <= CNT_W'(FIRST_WAIT);
          state_q <= S_ACCESS;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rom_sel  = sel_q;
  assign rom_rd   = rd_q;
  assign rom_addr = addr_q;
endmodule

// File: rtl/brom_burst_seq_chk.sv
module brom_burst_seq_chk
  import brom_pkg::*;
#(
  parameter int ADDR_W = 24
)(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              rom_sel,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              wide_q
);
  p_strobe_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> rom_sel);

  p_start_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rom_sel && rom_rd && rom_addr[3:0] == 4'h0));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && $past(rom_rd) && rom_addr != $past(rom_addr))
      |-> (rom_addr == $past(rom_addr) + (wide_q ? ADDR_W'(2) : ADDR_W'(1))));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && !rom_rd));

  p_sel_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_sel) |-> !$past(rom_rd));

  p_restart_together_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_sel) |-> rom_rd);

  p_cfg_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~CFG_MASK) == '0);
endmodule

bind brom_burst_seq brom_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .rom_sel   (rom_sel),
  .rom_rd    (rom_rd),
  .rom_addr  (rom_addr),
  .cfg_rdata (cfg_rdata),
  .wide_q    (wide_q)
);

// File: tb/brom_burst_seq_tb_top.sv
module brom_burst_seq_tb_top;
  localparam int AW = 24;
  localparam int FW = 3;
  localparam int NW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, done;
  logic [127:0]  rd_data;
  logic [AW-1:0] rom_addr;
  logic          rom_sel, rom_rd;
  logic [15:0]   rom_din = 16'hA5C3;

  always #5 clk = ~clk;

  brom_burst_seq #(.ADDR_W(AW), .FIRST_WAIT(FW), .NEXT_WAIT(NW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .done(done), .rd_data(rd_data), .rom_addr(rom_addr),
    .rom_sel(rom_sel), .rom_rd(rom_rd), .rom_din(rom_din)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [127:0]  data;
    logic [AW-1:0] base;
    int            ticks;
    int            bursts;
    int            hold;
  } exp_t;
  exp_t sb_q[$];

  bit tb_wide = 1'b0;
  bit tb_split = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [AW-1:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd7 + 8'h3D;
    return v ^ a[15:8];
  endfunction

  // ROM model: valid data only once the address has been stable long enough
  logic [AW-1:0] m_last_a = '0;
  bit            m_last_sel = 1'b0;
  bit            m_first = 1'b0;
  int            m_age = 0;
  always @(negedge clk) begin
    if (rom_sel && !m_last_sel) m_first = 1'b1;
    else if (rom_addr != m_last_a) m_first = 1'b0;
    if (rom_addr != m_last_a || (rom_sel && !m_last_sel)) m_age = 0;
    else m_age++;
    m_last_a   = rom_addr;
    m_last_sel = rom_sel;
    if (rom_sel && rom_rd && m_age >= (m_first ? FW : NW))
      rom_din <= tb_wide ? {byte_of(rom_addr + AW'(1)), byte_of(rom_addr)}
                         : {8'hEE, byte_of(rom_addr)};
    else
      rom_din <= 16'hA5C3;
  end

  // Monitor / scoreboard
  bit            p_busy = 1'b0, p_sel = 1'b0, p_rd = 1'b0, p_holdw = 1'b0;
  logic [AW-1:0] p_addr = '0;
  int            n_ticks = 0, n_bursts = 0, n_hold = 0, n_gap = 0, n_done = 0;
  logic [127:0]  got = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) n_ticks++;
      if (busy && !rom_sel) n_gap++;
      if (busy && !p_busy && sb_q.size() > 0)
        chk(rom_addr == sb_q[0].base && rom_sel && rom_rd, "R3 start address",
            128'(rom_addr), 128'(sb_q[0].base));
      if (rom_sel && !p_sel) n_bursts++;
      if (rom_rd && p_rd && rom_addr != p_addr)
        chk(rom_addr == p_addr + (tb_wide ? AW'(2) : AW'(1)), "R6 address step",
            128'(rom_addr), 128'(p_addr + (tb_wide ? AW'(2) : AW'(1))));
      if (rom_sel && !rom_rd) n_hold++;
      else if (p_holdw) begin
        if (sb_q.size() > 0)
          chk(n_hold == sb_q[0].hold, "R7 hold ticks", 128'(n_hold), 128'(sb_q[0].hold));
        chk(rom_addr == '0, "R7 address released", 128'(rom_addr), 128'(0));
        n_hold = 0;
      end
      if (done) begin
        n_done++;
        got = rd_data;
        chk(busy, "R11 busy during done", 128'(busy), 128'(1));
      end
      if (!busy && p_busy) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R12 unexpected transfer", 128'(1), 128'(0));
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(got == e.data, "R10 assembled line", got, e.data);
          chk(n_ticks == e.ticks, "R9 busy ticks", 128'(n_ticks), 128'(e.ticks));
          chk(n_bursts == e.bursts, tb_split ? "R5 burst count" : "R4 burst count",
              128'(n_bursts), 128'(e.bursts));
          chk(n_gap == e.bursts - 1, "R8 select gap ticks", 128'(n_gap), 128'(e.bursts - 1));
          chk(n_done == 1, "R11 single done pulse", 128'(n_done), 128'(1));
        end
        n_ticks = 0; n_bursts = 0; n_gap = 0; n_done = 0;
      end
      p_busy  = busy;
      p_sel   = rom_sel;
      p_rd    = rom_rd;
      p_addr  = rom_addr;
      p_holdw = rom_sel && !rom_rd;
    end
  end

  // Driver
  task automatic run_xfer(input bit wide, input bit split, input logic [1:0] hold,
                          input logic [AW-1:0] addr, input bit inject);
    exp_t e;
    int bpb, nb;
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {22'h0, hold, 4'h0, split, 2'b00, wide};
    @(negedge clk);
    cfg_we   = 1'b0;
    tb_wide  = wide;
    tb_split = split;
    bpb = split ? (wide ? 2 : 4) : (wide ? 8 : 16);
    nb  = split ? 4 : 1;
    e.base   = {addr[AW-1:4], 4'h0};
    e.hold   = 2 * int'(hold) + 1;
    e.bursts = nb;
    e.ticks  = nb * ((FW + 1) + (bpb - 1) * (NW + 1) + e.hold) + (nb - 1);
    for (int i = 0; i < 16; i++) e.data[i*8 +: 8] = byte_of(e.base + AW'(i));
    sb_q.push_back(e);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = addr ^ AW'(24'h00_0F30);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && !rom_sel, "R12 no extra transfer", 128'(busy), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 busy/done reset", 128'({busy, done}), 128'(0));
    chk(!rom_sel && !rom_rd, "R1 strobes reset", 128'({rom_sel, rom_rd}), 128'(0));
    chk(cfg_rdata == 32'h0, "R1 config reset", 128'(cfg_rdata), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == 32'h0000_0309, "R2 unused bits read zero", 128'(cfg_rdata),
        128'(32'h0000_0309));
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FCF6;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_rdata == 32'h0, "R2 field clear", 128'(cfg_rdata), 128'(0));

    run_xfer(1'b1, 1'b0, 2'd0, 24'h01_2345, 1'b0);
    run_xfer(1'b0, 1'b0, 2'd3, 24'h00_ABC0, 1'b1);
    run_xfer(1'b1, 1'b1, 2'd1, 24'h7F_FFF7, 1'b1);
    run_xfer(1'b0, 1'b1, 2'd2, 24'h00_0008, 1'b0);
    run_xfer(1'b0, 1'b1, 2'd0, 24'h12_3F1C, 1'b0);
    run_xfer(1'b1, 1'b1, 2'd3, 24'h00_0000, 1'b0);
    run_xfer(1'b1, 1'b0, 2'd2, 24'hFF_FFF0, 1'b1);

    chk(sb_q.size() == 0, "R11 all transfers completed", 128'(sb_q.size()), 128'(0));
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule